// File: doc/BRIEF.md
# Two-Priority Message Dispatch Unit

The unit receives the words of arriving messages on a single input port, each word tagged with a priority, and holds them in two independent circular queues, one for priority zero and one for priority one. The first word of every message is a header that carries the handler address and the total length of the message in words. Once a whole message sits at the head of a queue, the unit starts a handler task for it. The dispatch takes a fixed number of cycles, four by default. It loads the instruction pointer from the header, points a base register at the message and steps through the fetch and decode phases.

Each execution level has its own register set: background, priority zero and priority one. A priority-one message is dispatched even while a priority-zero handler runs, and the suspended handler resumes with its registers intact when the priority-one handler finishes. A pending priority-one message always wins over a pending priority-zero one. The background level runs whenever no handler is active. A handler ends with a one-cycle `done` pulse. The pulse retires its message, advances the queue head by the message length and hands control to the highest level that still has work.

Top module: `msg_dispatch`

## Requirements
- R1: A header word holds the message length in words (header included) in bits [15:12] and the handler address in bits [11:0]. A length field of 0 is treated as 1.
- R2: A word is stored at the tail of queue `in_pri` on a rising edge where `in_valid` is high and `in_ready[in_pri]` is high. Priority 0 selects queue zero and priority 1 selects queue one, and the queues do not interact.
- R3: `in_ready[p]` is low exactly while queue `p` holds DEPTH words (16 by default), and it returns high the cycle after a retirement frees space.
- R4: While the target level is free, dispatch begins on the first edge after the last word of a message is stored. `disp_o` then stays high for exactly four cycles with `phase_o` counting 0, 1, 2, 3, and `run_o` rises in the following cycle. No dispatch starts while only part of a message is buffered.
- R5: From the first dispatch cycle, `ip_o` equals the handler address of the message and `base_o` equals {priority, queue index of its header}.
- R6: `rset_o` gives the active register set: 0 for background, 1 for priority zero, 2 for priority one.
- R7: When complete messages are pending in both queues and no handler is active, the priority-one message is dispatched first.
- R8: A complete priority-one message preempts a running priority-zero handler. When the priority-one handler finishes, the priority-zero handler continues at once (`rset_o`=1, `run_o`=1) with its `ip_o` and `base_o` unchanged and no new dispatch.
- R9: A `done` pulse while `run_o` is high retires the running message. The next message of that priority is then based at the old head plus the effective length, modulo DEPTH.
- R10: A `done` pulse while `run_o` is low (background or mid-dispatch) retires nothing and does not disturb a dispatch in progress.
- R11: With no handler active, `rset_o` is 0, `run_o` is 0 and `ip_o` shows the background address (0xF00 by default).
- R12: A level runs at most one handler at a time. Further complete messages of an active level wait until its handler finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input word is offered |
| in_pri | input | 1 | Priority of the offered word |
| in_data | input | 16 | Offered message word |
| in_ready | output | 2 | Per-priority space available |
| done | input | 1 | Running handler has finished |
| ip_o | output | 12 | Instruction pointer of the active level |
| base_o | output | 5 | Message base pointer {priority, queue index} |
| rset_o | output | 2 | Active register set index |
| disp_o | output | 1 | Dispatch sequence in progress |
| phase_o | output | 2 | Dispatch phase number |
| run_o | output | 1 | A handler is executing |

## Verification
Every length field from 0 to 8 is swept in both queues, so the header decode, the timing of the four dispatch phases and the head advance (including wrap-around) are each checked against an arithmetic model of the queue index. A run of sixteen one-word messages fills a queue to expose backpressure and the one-handler-per-level rule, and it drains to show the queue recovers. Separate patterns overlap the levels. One starts a priority-one message during a priority-zero handler, which shows preemption and an intact resume. Another queues both priorities behind a running handler, which shows the arbitration order. Stray `done` pulses, in background and mid-dispatch, show up later as a wrong base pointer if they ever retire a message.

// File: rtl/msgd_pkg.sv
package msgd_pkg;

   // Execution levels; numeric value is also the register-set index
   typedef enum logic [1:0] {
      LVL_BG = 2'd0,
      LVL_P0 = 2'd1,
      LVL_P1 = 2'd2
   } lvl_e;

endpackage

// File: rtl/msgd_queue.sv
module msgd_queue #(
   parameter  int W     = 16,
   parameter  int LEN_W = 4,
   parameter  int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int IP_W  = W - LEN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic             ready,
   output logic             complete,
   output logic [PTR_W-1:0] head_o,
   output logic [IP_W-1:0]  haddr
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("msgd_queue: DEPTH must be a power of two >= 2");
   end
   if (((1 << LEN_W) - 1) > DEPTH) begin : g_bad_len
      $error("msgd_queue: longest message must fit in the queue");
   end
   if (IP_W < 1) begin : g_bad_w
      $error("msgd_queue: word too narrow for a handler address");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] head, tail;
   logic [CNT_W-1:0] count;
   logic [W-1:0]     hword;
   logic [LEN_W-1:0] raw_len, hlen;

   assign hword    = mem[head];
   assign raw_len  = hword[W-1 -: LEN_W];
   assign hlen     = (raw_len == '0) ? LEN_W'(1) : raw_len;
   assign haddr    = hword[IP_W-1:0];
   assign head_o   = head;
   assign ready    = (count < CNT_W'(DEPTH));
   assign complete = (count != '0) && (count >= CNT_W'(hlen));

   always_ff @(posedge clk) begin
      if (push) mem[tail] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (push) tail <= tail + 1'b1;
         if (pop)  head <= head + PTR_W'(hlen);
         count <= count + CNT_W'(push) - (pop ? CNT_W'(hlen) : CNT_W'(0));
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R3
   AST_POP_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> complete); // R9
   AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH)) |-> !push); // R3

endmodule

// File: rtl/msgd_sched.sv
module msgd_sched
   import msgd_pkg::*;
#(
   parameter  int DISP_CYCLES = 4,
   localparam int DC_W = $clog2(DISP_CYCLES + 1),
   localparam int PH_W = $clog2(DISP_CYCLES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      pend,
   input  logic            done,
   output logic            start,
   output logic            start_p1,
   output logic [1:0]      pop,
   output lvl_e            cur_o,
   output logic            disp,
   output logic [PH_W-1:0] phase,
   output logic            run
);

   if (DISP_CYCLES < 2) begin : g_bad_cycles
      $error("msgd_sched: DISP_CYCLES must be at least 2");
   end

   lvl_e            cur;
   logic [DC_W-1:0] dcnt;
   logic            p0_act, p1_act;
   logic            idle, go1, go0, fin;

   assign idle     = (dcnt == '0);
   assign go1      = idle && pend[1] && !p1_act;
   assign go0      = idle && pend[0] && !p0_act && !p1_act && !pend[1];
   assign start    = go1 || go0;
   assign start_p1 = go1;
   assign run      = idle && (cur != LVL_BG);
   assign fin      = done && run;
   assign pop[1]   = fin && (cur == LVL_P1);
   assign pop[0]   = fin && (cur == LVL_P0);
   assign cur_o    = cur;
   assign disp     = !idle;
   assign phase    = idle ? '0 : PH_W'(dcnt - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur    <= LVL_BG;
         dcnt   <= '0;
         p0_act <= 1'b0;
         p1_act <= 1'b0;
      end else begin
         if (go1)      p1_act <= 1'b1;
         else if (pop[1]) p1_act <= 1'b0;
         if (go0)      p0_act <= 1'b1;
         else if (pop[0]) p0_act <= 1'b0;

         if (start) begin
            cur  <= go1 ? LVL_P1 : LVL_P0;
            dcnt <= DC_W'(1);
         end else begin
            if (fin) cur <= ((cur == LVL_P1) && p0_act) ? LVL_P0 : LVL_BG;
            if (!idle) dcnt <= (dcnt == DC_W'(DISP_CYCLES)) ? '0 : dcnt + 1'b1;
         end
      end
   end

   AST_DISP_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (dcnt != '0 && dcnt != DC_W'(DISP_CYCLES)) |=> (dcnt == $past(dcnt) + 1'b1)); // R4
   AST_RESUME_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cur == LVL_P0) |-> p0_act); // R8
   AST_P1_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
      pop[1] |=> (cur != LVL_P1)); // R8
   AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pop) <= 1); // R9

endmodule

// File: rtl/msgd_regset.sv
module msgd_regset
   import msgd_pkg::*;
#(
   parameter  int          IP_W  = 12,
   parameter  int          PTR_W = 4,
   parameter  int unsigned BG_IP = 'hF00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_p1,
   input  logic [IP_W-1:0]  new_ip,
   input  logic [PTR_W:0]   new_base,
   input  lvl_e             cur,
   output logic [IP_W-1:0]  ip_o,
   output logic [PTR_W:0]   base_o
);

   logic [IP_W-1:0] ip_q   [2];
   logic [PTR_W:0]  base_q [2];

   for (genvar l = 0; l < 2; l++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ip_q[l]   <= '0;
            base_q[l] <= '0;
         end else if (start && (start_p1 == (l == 1))) begin
            ip_q[l]   <= new_ip;
            base_q[l] <= new_base;
         end
      end
   end

   always_comb begin
      case (cur)
         LVL_P0: begin
            ip_o   = ip_q[0];
            base_o = base_q[0];
         end
         LVL_P1: begin
            ip_o   = ip_q[1];
            base_o = base_q[1];
         end
         default: begin
            ip_o   = IP_W'(BG_IP);
            base_o = '0;
         end
      endcase
   end

   AST_BASE_PRI: assert property (@(posedge clk) disable iff (!rst_n)
      (cur != LVL_BG) |-> (base_o[PTR_W] == (cur == LVL_P1))); // R5

endmodule

// File: rtl/msg_dispatch.sv
module msg_dispatch
   import msgd_pkg::*;
#(
   parameter  int          W           = 16,
   parameter  int          LEN_W       = 4,
   parameter  int          DEPTH       = 16,
   parameter  int          DISP_CYCLES = 4,
   parameter  int unsigned BG_IP       = 'hF00,
   localparam int          IP_W        = W - LEN_W,
   localparam int          PTR_W       = $clog2(DEPTH),
   localparam int          PH_W        = $clog2(DISP_CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_pri,
   input  logic [W-1:0]     in_data,
   output logic [1:0]       in_ready,
   input  logic             done,
   output logic [IP_W-1:0]  ip_o,
   output logic [PTR_W:0]   base_o,
   output logic [1:0]       rset_o,
   output logic             disp_o,
   output logic [PH_W-1:0]  phase_o,
   output logic             run_o
);

   logic [1:0]       push, pop, pend;
   logic [PTR_W-1:0] qhead [2];
   logic [IP_W-1:0]  qaddr [2];
   logic             start, start_p1;
   lvl_e             cur;

   for (genvar p = 0; p < 2; p++) begin : g_q
      assign push[p] = in_valid && (in_pri == (p == 1)) && in_ready[p];
      msgd_queue #(.W(W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_q (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (push[p]),
         .wdata    (in_data),
         .pop      (pop[p]),
         .ready    (in_ready[p]),
         .complete (pend[p]),
         .head_o   (qhead[p]),
         .haddr    (qaddr[p])
      );
   end

   msgd_sched #(.DISP_CYCLES(DISP_CYCLES)) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend     (pend),
      .done     (done),
      .start    (start),
      .start_p1 (start_p1),
      .pop      (pop),
      .cur_o    (cur),
      .disp     (disp_o),
      .phase    (phase_o),
      .run      (run_o)
   );

   msgd_regset #(.IP_W(IP_W), .PTR_W(PTR_W), .BG_IP(BG_IP)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .start_p1 (start_p1),
      .new_ip   (start_p1 ? qaddr[1] : qaddr[0]),
      .new_base ({start_p1, start_p1 ? qhead[1] : qhead[0]}),
      .cur      (cur),
      .ip_o     (ip_o),
      .base_o   (base_o)
   );

   assign rset_o = cur;

   AST_RUN_NOT_BG: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> (rset_o != 2'd0)); // R11
   AST_P1_BEFORE_P0: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[1] && !disp_o && rset_o != 2'd2) |=> (rset_o == 2'd2)); // R7

endmodule

// File: tb/sim_msg_dispatch.sv
module sim_msg_dispatch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_pri = 1'b0;
   logic [15:0] in_data = '0;
   logic [1:0]  in_ready;
   logic        done = 1'b0;
   logic [11:0] ip_o;
   logic [4:0]  base_o;
   logic [1:0]  rset_o;
   logic        disp_o;
   logic [1:0]  phase_o;
   logic        run_o;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;
   int hd [2];

   always #2 clk = ~clk;

   msg_dispatch u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pri(in_pri),
      .in_data(in_data), .in_ready(in_ready), .done(done), .ip_o(ip_o),
      .base_o(base_o), .rset_o(rset_o), .disp_o(disp_o), .phase_o(phase_o),
      .run_o(run_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input bit p, input logic [15:0] w);
      @(negedge clk);
      in_valid = 1'b1; in_pri = p; in_data = w;
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk);
      done = 1'b1;
      @(posedge clk);
      #1 done = 1'b0;
   endtask

   task automatic wait_run();
      do @(negedge clk); while (!run_o);
   endtask

   // Called right after the edge that makes a message dispatchable
   task automatic chk_dispatch(input bit p, input logic [11:0] addr, input int pre_rset);
      logic [4:0] eb;
      eb = {p, 4'(hd[p])};
      @(negedge clk);
      chk("R4 no dispatch yet", {31'd0, disp_o}, 32'd0);
      chk("R6 level before", {30'd0, rset_o}, pre_rset);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R4 disp_o", {31'd0, disp_o}, 32'd1);
         chk("R4 phase", {30'd0, phase_o}, k);
         chk("R6 rset", {30'd0, rset_o}, p ? 2 : 1);
         chk("R5 ip", {20'd0, ip_o}, addr);
         chk("R5 base", {27'd0, base_o}, eb);
      end
      @(negedge clk);
      chk("R4 run after phases", {30'd0, run_o, disp_o}, 32'd2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      hd[0] = 0; hd[1] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset rset", {30'd0, rset_o}, 0);
      chk("R11 reset ip", {20'd0, ip_o}, 32'hF00);
      chk("R11 reset run/disp", {30'd0, run_o, disp_o}, 0);
      chk("R3 reset ready", {30'd0, in_ready}, 3);

      // R10: done in background retires nothing (first base checks head 0)
      pulse_done();
      @(negedge clk);
      chk("R10 bg done rset", {30'd0, rset_o}, 0);
      chk("R10 bg done run", {31'd0, run_o}, 0);

      // R1 R2 R9 sweep over lengths and priorities
      for (int p = 0; p < 2; p++) begin
         for (int len = 0; len <= 8; len++) begin
            logic [11:0] a;
            int eff;
            a = 12'(256 * (p + 1) + 16 * len + 5);
            eff = (len == 0) ? 1 : len;
            push(p[0], {4'(len), a});
            if (eff > 1) begin
               @(negedge clk);
               @(negedge clk);
               chk("R4 partial msg held", {30'd0, rset_o, disp_o}, 0);
               for (int j = 1; j < eff - 1; j++) push(p[0], 16'(j));
               push(p[0], 16'hABCD);
            end
            chk_dispatch(p[0], a, 0);
            pulse_done();
            @(negedge clk);
            chk("R11 back to bg", {30'd0, rset_o}, 0);
            chk("R11 bg ip", {20'd0, ip_o}, 32'hF00);
            hd[p] = (hd[p] + eff) % 16;
         end
      end

      // R3 R12 fill queue zero with one-word messages
      for (int i = 0; i < 16; i++) push(1'b0, {4'd1, 12'(12'h200 + i)});
      @(negedge clk);
      chk("R3 full ready", {30'd0, in_ready}, 2);
      chk("R12 one handler", {20'd0, ip_o}, 32'h200);
      chk("R12 running p0", {30'd0, rset_o}, 1);
      pulse_done();
      hd[0] = (hd[0] + 1) % 16;
      @(negedge clk);
      chk("R3 ready returns", {30'd0, in_ready}, 3);
      for (int i = 1; i < 16; i++) begin
         wait_run();
         chk("R9 drain ip", {20'd0, ip_o}, 12'h200 + i);
         chk("R9 drain base", {27'd0, base_o}, {1'b0, 4'(hd[0])});
         pulse_done();
         hd[0] = (hd[0] + 1) % 16;
      end
      @(negedge clk);
      chk("R11 drained", {30'd0, rset_o}, 0);

      // R8 preemption and resume
      begin
         logic [4:0] b0;
         push(1'b0, {4'd2, 12'h111});
         push(1'b0, 16'h0001);
         b0 = {1'b0, 4'(hd[0])};
         wait_run();
         push(1'b1, {4'd1, 12'h222});
         chk_dispatch(1'b1, 12'h222, 1);
         pulse_done();
         hd[1] = (hd[1] + 1) % 16;
         @(negedge clk);
         chk("R8 resume rset", {30'd0, rset_o}, 1);
         chk("R8 resume run", {31'd0, run_o}, 1);
         chk("R8 resume ip", {20'd0, ip_o}, 32'h111);
         chk("R8 resume base", {27'd0, base_o}, b0);
         pulse_done();
         hd[0] = (hd[0] + 2) % 16;
         @(negedge clk);
         chk("R11 after resume", {30'd0, rset_o}, 0);
      end

      // R7 both pending: priority one first
      push(1'b1, {4'd1, 12'h333});
      chk_dispatch(1'b1, 12'h333, 0);
      hd[1] = (hd[1] + 1) % 16;
      push(1'b0, {4'd1, 12'h444});
      push(1'b1, {4'd1, 12'h555});
      @(negedge clk);
      chk("R12 p1 waits", {20'd0, ip_o}, 32'h333);
      pulse_done();
      chk_dispatch(1'b1, 12'h555, 0);
      pulse_done();
      hd[1] = (hd[1] + 1) % 16;
      chk_dispatch(1'b0, 12'h444, 0);
      pulse_done();
      hd[0] = (hd[0] + 1) % 16;

      // R10 done during dispatch is ignored
      push(1'b0, {4'd1, 12'h666});
      @(negedge clk);
      @(negedge clk);
      chk("R10 phase0", {30'd0, phase_o}, 0);
      done = 1'b1;
      @(posedge clk);
      #1 done = 1'b0;
      @(negedge clk);
      chk("R10 disp continues", {29'd0, disp_o, phase_o}, 5);
      repeat (3) @(negedge clk);
      chk("R10 runs after", {30'd0, run_o, disp_o}, 2);
      chk("R10 still p0", {30'd0, rset_o}, 1);
      pulse_done();
      hd[0] = (hd[0] + 1) % 16;
      push(1'b0, {4'd1, 12'h777});
      chk_dispatch(1'b0, 12'h777, 0);
      pulse_done();

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule